// File: doc/BRIEF.md
# Packed-Lane Logical Left Shifter with Sticky Overflow

This datapath unit shifts a 32-bit word left by an immediate amount. The word is split into independent lanes: either two 16-bit halfwords or four 8-bit bytes. Bits never cross from one lane into the next. The result always holds the wrapped value. It is not saturated, even when the shift overflows.

Each lane checks the bits that the shift pushes out of it. A halfword lane treats the value as signed and reports overflow when the shift changes its sign or loses significant bits. A byte lane treats the value as unsigned and reports overflow when any 1 bit falls off the top. If any lane reports overflow, a sticky status bit is set. That bit sits at position 22 of a small control word. Software can write the control word directly and read it back on its own port. Clearing the word before an operation leaves the bit showing only that operation's outcome.

Top module: `packed_shl_unit`

## Requirements
- R1: With `lane_byte`=0 (halfword mode), each 16-bit lane (bits 31:16 and 15:0) is shifted left by `shamt` (0 to 15). Zeros fill the bottom of each lane. Bits shifted out of the lower lane do not enter the upper lane, and the wrapped value is written.
- R2: With `lane_byte`=1 (byte mode), each 8-bit lane is shifted left by `shamt[2:0]` (0 to 7). No bits cross between lanes, and `shamt[3]` has no effect.
- R3: In halfword mode, a lane overflows when any bit in positions 15 down to 15-`shamt` of the original lane differs from its bit 15. This covers both the discarded bits and the bit that becomes the new bit 15.
- R4: In byte mode, a lane overflows only when a discarded bit (original positions 7 down to 8-`shamt[2:0]`) is 1. A bit that moves into position 7 is not overflow.
- R5: An effective shift amount of zero returns the operand unchanged and never sets the overflow flag.
- R6: `result` and `res_valid` update on the clock edge that samples `in_valid`=1. `res_valid` is 1 only in the cycle after an accepted operation. `result` holds its value while no operation is accepted.
- R7: The overflow flag is sticky. An accepted operation in which any lane overflows sets it. Any other operation leaves it unchanged.
- R8: When `csr_we`=1, the flag is loaded from `csr_wdata[22]`. This write takes priority over a set from an operation in the same cycle.
- R9: `csr_rdata[22]` shows the flag, and every other bit of `csr_rdata` reads 0. After reset, the flag, `result` and `res_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept an operation this cycle |
| lane_byte | input | 1 | Lane mode: 0 selects halfword lanes, 1 selects byte lanes |
| shamt | input | 4 | Immediate shift amount |
| operand | input | 32 | Packed input word |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Data for the control word write (bit 22 is used) |
| result | output | 32 | Registered shifted word |
| res_valid | output | 1 | A new result is on `result` |
| csr_rdata | output | 32 | Control word read-back, with the flag at bit 22 |

## Verification
Two events can hit the flag register in the same cycle: a control-word write and an overflowing operation. The bench creates this collision on purpose. It drives `csr_we` and `in_valid` together, using an operand known to overflow with a write of 0, and a non-overflowing operand with a write of 1. After the edge it checks that `csr_rdata[22]` shows the written value. During the random phase, writes and operations also coincide by chance. The bench's flag model applies the write last, so every one of those collisions is checked by the same rule.

// File: rtl/packed_shl_unit.sv
module packed_shl_unit #(
  parameter int FLAG_BIT = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        lane_byte,
  input  logic [3:0]  shamt,
  input  logic [31:0] operand,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] result,
  output logic        res_valid,
  output logic [31:0] csr_rdata
);

  function automatic logic half_ovf(input logic [15:0] h, input logic [3:0] s);
    logic [15:0] top;
    logic [16:0] ones;
    top  = h >> (4'd15 - s);
    ones = (17'd1 << ({1'b0, s} + 5'd1)) - 17'd1;
    return h[15] ? (top != ones[15:0]) : (top != 16'd0);
  endfunction

  function automatic logic byte_ovf(input logic [7:0] b, input logic [2:0] s);
    logic [7:0] top;
    top = b >> (4'd8 - {1'b0, s});
    return top != 8'd0;
  endfunction

  logic [31:0] h_res, b_res;
  logic [1:0]  h_ov;
  logic [3:0]  b_ov;
  logic        flag;

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign h_res[16*g +: 16] = operand[16*g +: 16] << shamt;
    assign h_ov[g]           = half_ovf(operand[16*g +: 16], shamt);
  end

  for (genvar g = 0; g < 4; g++) begin : g_byte
    assign b_res[8*g +: 8] = operand[8*g +: 8] << shamt[2:0];
    assign b_ov[g]         = byte_ovf(operand[8*g +: 8], shamt[2:0]);
  end

  wire        any_ov = lane_byte ? |b_ov : |h_ov;
  wire [31:0] nxt    = lane_byte ? b_res : h_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      res_valid <= 1'b0;
      flag      <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= nxt;
      if (csr_we)                 flag <= csr_wdata[FLAG_BIT];
      else if (in_valid && any_ov) flag <= 1'b1;
    end
  end

  assign csr_rdata = 32'(flag) << FLAG_BIT;

endmodule

// File: rtl/packed_shl_chk.sv
module packed_shl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        lane_byte,
  input logic [3:0]  shamt,
  input logic [31:0] operand,
  input logic        csr_we,
  input logic [31:0] csr_wdata,
  input logic [31:0] result,
  input logic        res_valid,
  input logic [31:0] csr_rdata
);

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  a_r6_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r5_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !csr_we && !csr_rdata[22] &&
     (lane_byte ? shamt[2:0] == 3'd0 : shamt == 4'd0))
    |=> (result == $past(operand)) && !csr_rdata[22]);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> csr_rdata[22] == $past(csr_wdata[22]));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we && csr_rdata[22]) |=> csr_rdata[22]);

  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we && !in_valid) |=> $stable(csr_rdata[22]));

  a_r9_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~(32'd1 << 22)) == 32'd0);

endmodule

bind packed_shl_unit packed_shl_chk u_chk (.*);

// File: tb/packed_shl_unit_tb.sv
module packed_shl_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        lane_byte = 1'b0;
  logic [3:0]  shamt = '0;
  logic [31:0] operand = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] result;
  logic        res_valid;
  logic [31:0] csr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_flag = 1'b0;

  packed_shl_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] model(input logic [31:0] x, input logic bm, input logic [3:0] s);
    logic [31:0] r;
    logic o;
    int k;
    r = '0; o = 1'b0;
    if (bm) begin
      k = int'(s[2:0]);
      for (int l = 0; l < 4; l++) begin
        for (int i = 0; i < 8; i++) begin
          if (i + k < 8) r[8*l + i + k] = x[8*l + i];
          else if (x[8*l + i]) o = 1'b1;
        end
      end
    end else begin
      k = int'(s);
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < 16; i++) begin
          if (i + k < 16) r[16*l + i + k] = x[16*l + i];
          if (i >= 15 - k && x[16*l + i] != x[16*l + 15]) o = 1'b1;
        end
      end
    end
    return {o, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] x, input logic bm,
                        input logic [3:0] s, input logic we, input logic [31:0] wd);
    logic [32:0] m;
    m = model(x, bm, s);
    @(negedge clk);
    in_valid = 1'b1; operand = x; lane_byte = bm; shamt = s;
    csr_we = we; csr_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; csr_we = 1'b0;
    if (we) exp_flag = wd[22];
    else if (m[32]) exp_flag = 1'b1;
    check({req, " result"}, result, m[31:0]);
    check({req, " valid"}, {31'd0, res_valid}, 32'd1);
    check({req, " flag"}, csr_rdata, {9'd0, exp_flag, 22'd0});
  endtask

  task automatic clear_flag();
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = 32'd0;
    @(negedge clk);
    csr_we = 1'b0;
    exp_flag = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset result", result, 32'd0);
    check("R9 reset valid", {31'd0, res_valid}, 32'd0);
    check("R9 reset flag", csr_rdata, 32'd0);
    rst_n = 1'b1;

    clear_flag();
    run_op("R1 R3", 32'h7fff8000, 1'b0, 4'd1, 1'b0, 32'd0);
    clear_flag();
    run_op("R3", 32'h00000001, 1'b0, 4'd15, 1'b0, 32'd0);
    clear_flag();
    run_op("R4", 32'h00000001, 1'b1, 4'd7, 1'b0, 32'd0);
    clear_flag();
    run_op("R2 R4", 32'h87654321, 1'b1, 4'd3, 1'b0, 32'd0);
    clear_flag();
    run_op("R2 shamt3 ignored", 32'h87654321, 1'b1, 4'b1011, 1'b0, 32'd0);
    clear_flag();
    run_op("R1 no cross", 32'h0000ffff, 1'b0, 4'd4, 1'b0, 32'd0);
    clear_flag();
    run_op("R3 negative ok", 32'hfff0c000, 1'b0, 4'd1, 1'b0, 32'd0);
    clear_flag();
    run_op("R5 half", 32'h80017fff, 1'b0, 4'd0, 1'b0, 32'd0);
    run_op("R5 byte", 32'hff80017f, 1'b1, 4'd8, 1'b0, 32'd0);

    run_op("R7 set", 32'h00004000, 1'b0, 4'd1, 1'b0, 32'd0);
    run_op("R7 stays", 32'h00000001, 1'b0, 4'd1, 1'b0, 32'd0);
    run_op("R8 write0 wins", 32'h40000000, 1'b0, 4'd2, 1'b1, 32'd0);
    run_op("R8 write1 wins", 32'h00000001, 1'b1, 4'd1, 1'b1, 32'hffffffff);
    check("R9 other bits", csr_rdata, 32'h00400000);

    hold = result;
    @(negedge clk);
    operand = 32'hdeadbeef; shamt = 4'd5;
    @(negedge clk);
    @(negedge clk);
    check("R6 hold", result, hold);
    check("R6 valid low", {31'd0, res_valid}, 32'd0);
    check("R7 idle", csr_rdata, 32'h00400000);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] x;
      logic bm, we;
      logic [3:0] s;
      x = $urandom;
      if (n % 3 == 0) x = x & 32'h00ff00ff;
      bm = 1'($urandom);
      s = 4'($urandom);
      we = ($urandom % 8) == 0;
      run_op("R1 R2 R3 R4 R7 R8 random", x, bm, s, we, {9'd0, 1'($urandom), 22'd0});
      if (($urandom % 10) == 0) clear_flag();
    end

    finish_run();
  end
endmodule